// File: doc/BRIEF.md
# Stretchable External Memory Cycle Generator

This block produces the bus timing for one external data memory access of a small 8-bit controller. A one-clock start request, together with a read/write select, an address and write data, opens an access window. During the window the block drives the address bus with an address-valid flag and pulses the read or the write strobe. A 3-bit stretch setting adds clocks to the window so that slow memories can be served. Reads and writes follow different length rules.

The stretch value is taken when the request is accepted and is held for the whole access. On a read, the byte presented by the memory is captured on the last strobe clock. Every access ends with a one-clock done pulse. Only one access runs at a time. Busy is high for the whole window, and a request that arrives while busy is high is dropped.

Top module: `xmem_cycle_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `addr_valid`, `rd_stb`, `wr_stb`, `done` and `busy` are low, and `mem_addr`, `mem_wdata` and `rdata_out` are zero.
- R2: The setting on `stretch_sel` (binary value s, 0 to 7) is sampled in the cycle `start` is accepted. Changes to `stretch_sel` during an access have no effect on that access.
- R3: A read (`wr_sel`=0) accepted at a clock edge makes `addr_valid` high for exactly s+1 clocks, starting at that edge. During those clocks `mem_addr` holds the address sampled at acceptance. At all other times `mem_addr` is zero.
- R4: During a read, `rd_stb` is high in exactly the same clocks as `addr_valid` (s+1 clocks), and `wr_stb` stays low.
- R5: A write (`wr_sel`=1) makes `addr_valid` high for exactly s+2 clocks. During those clocks `mem_wdata` holds the write data sampled at acceptance. At all other times it is zero.
- R6: During a write, `wr_stb` goes high on the second clock of the window. It stays high for 1 clock when s is 0 or 1, and for s clocks otherwise. `rd_stb` stays low.
- R7: On a read, `rdata_out` takes the value of `mem_rdata` from the last clock of the read strobe. It holds that value until the next read completes. Writes leave it unchanged.
- R8: `done` is high for exactly one clock, in the clock right after the last `addr_valid` clock of every access.
- R9: `busy` equals `addr_valid`. A `start` while `busy` is high is ignored, including its address, data, direction and stretch.
- R10: `rd_stb` and `wr_stb` are never high together, and neither is high outside `addr_valid`.
- R11: A `start` presented in the `done` clock is accepted, so back-to-back accesses are separated by exactly one idle clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stretch_sel | input | 3 | Stretch value s, binary 0 to 7 |
| start | input | 1 | Access request, sampled each clock |
| wr_sel | input | 1 | 1 = write, 0 = read |
| addr_in | input | AW (16) | Access address |
| wdata_in | input | DW (8) | Write data |
| mem_rdata | input | DW (8) | Data returned by the memory |
| mem_addr | output | AW (16) | Address bus, zero when idle |
| mem_wdata | output | DW (8) | Write data bus, zero outside writes |
| addr_valid | output | 1 | Address window active |
| rd_stb | output | 1 | Read strobe, active high |
| wr_stb | output | 1 | Write strobe, active high |
| rdata_out | output | DW (8) | Captured read data |
| done | output | 1 | One-clock completion pulse |
| busy | output | 1 | Access in progress |

## Verification
The two events that share a clock are the done pulse that closes one access and the acceptance of the next request. Holding `start` high across several accesses provokes this, with the stretch, direction and address changing between them. The bench model expects the next window to open one clock after done, with no second done pulse and no loss of the captured read byte. A second collision, a request while busy with fresh address and stretch values, is judged by checking that the running window's length and address bus do not change.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
  localparam int SW = 3;
  localparam int CW = SW + 2;

  // clocks the address stays valid
  function automatic logic [CW-1:0] win_len(input logic [SW-1:0] s, input logic wr);
    logic [CW-1:0] base;
    base = {{(CW-SW){1'b0}}, s};
    return wr ? base + 2 : base + 1;
  endfunction

  // clocks the write strobe stays high
  function automatic logic [CW-1:0] wstb_len(input logic [SW-1:0] s);
    logic [CW-1:0] base;
    base = {{(CW-SW){1'b0}}, s};
    return (s < 2) ? {{(CW-1){1'b0}}, 1'b1} : base;
  endfunction
endpackage

// File: rtl/xmem_seq.sv
module xmem_seq
  import xmem_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] stretch_sel,
  input  logic          start,
  input  logic          wr_sel,
  output logic          accept,
  output logic          active,
  output logic          wr_mode,
  output logic          last,
  output logic          cap_en,
  output logic          rd_stb,
  output logic          wr_stb,
  output logic          done
);
  logic [SW-1:0] s_q;
  logic [CW-1:0] cnt;
  logic [CW-1:0] len_w;
  logic [CW-1:0] wlen_w;

  assign len_w  = win_len(s_q, wr_mode);
  assign wlen_w = wstb_len(s_q);
  assign accept = start & ~active;
  assign last   = active & (cnt == len_w - 1'b1);
  assign cap_en = last & ~wr_mode;
  assign rd_stb = active & ~wr_mode;
  assign wr_stb = active & wr_mode & (cnt != '0) & (cnt <= wlen_w);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      wr_mode <= 1'b0;
      s_q     <= '0;
      cnt     <= '0;
      done    <= 1'b0;
    end else begin
      done <= last;
      if (accept) begin
        active  <= 1'b1;
        wr_mode <= wr_sel;
        s_q     <= stretch_sel;
        cnt     <= '0;
      end else if (active) begin
        if (last) active <= 1'b0;
        else      cnt    <= cnt + 1'b1;
      end
    end
  end

  assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stb && wr_stb));
  assert_strobe_in_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb || wr_stb) |-> active);
  assert_done_after_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> done);
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_stretch_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(s_q));
  assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && active && !last) |=> (active && cnt == $past(cnt) + 1'b1));
  assert_wstb_second_clock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_stb) |-> (cnt == 1));
endmodule

// File: rtl/xmem_dpath.sv
module xmem_dpath #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          active,
  input  logic          wr_mode,
  input  logic          cap_en,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] wdata_in,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [DW-1:0] rdata_out
);
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q    <= '0;
      wdata_q   <= '0;
      rdata_out <= '0;
    end else begin
      if (accept) begin
        addr_q  <= addr_in;
        wdata_q <= wdata_in;
      end
      if (cap_en) rdata_out <= mem_rdata;
    end
  end

  assign mem_addr  = active ? addr_q : '0;
  assign mem_wdata = (active && wr_mode) ? wdata_q : '0;

  assert_addr_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(mem_addr));
  assert_rdata_only_on_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cap_en) |-> $stable(rdata_out));
endmodule

// File: rtl/xmem_cycle_gen.sv
module xmem_cycle_gen
  import xmem_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    stretch_sel,
  input  logic          start,
  input  logic          wr_sel,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] wdata_in,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          addr_valid,
  output logic          rd_stb,
  output logic          wr_stb,
  output logic [DW-1:0] rdata_out,
  output logic          done,
  output logic          busy
);
  logic accept_w, active_w, wr_mode_w, last_w, cap_en_w;

  xmem_seq u_seq (
    .clk(clk), .rst_n(rst_n), .stretch_sel(stretch_sel), .start(start),
    .wr_sel(wr_sel), .accept(accept_w), .active(active_w), .wr_mode(wr_mode_w),
    .last(last_w), .cap_en(cap_en_w), .rd_stb(rd_stb), .wr_stb(wr_stb), .done(done)
  );

  xmem_dpath #(.AW(AW), .DW(DW)) u_dpath (
    .clk(clk), .rst_n(rst_n), .accept(accept_w), .active(active_w),
    .wr_mode(wr_mode_w), .cap_en(cap_en_w), .addr_in(addr_in),
    .wdata_in(wdata_in), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .rdata_out(rdata_out)
  );

  assign addr_valid = active_w;
  assign busy       = active_w;

  assert_capture_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en_w |-> (last_w && rd_stb));
endmodule

// File: tb/test_xmem_cycle_gen.sv
module test_xmem_cycle_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  stretch_sel = '0;
  logic        start = 1'b0;
  logic        wr_sel = 1'b0;
  logic [15:0] addr_in = '0;
  logic [7:0]  wdata_in = '0;
  logic [7:0]  mem_rdata;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, rdata_out;
  logic        addr_valid, rd_stb, wr_stb, done, busy;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  // memory answers with a pattern of the address
  assign mem_rdata = mem_addr[7:0] ^ mem_addr[15:8] ^ 8'hA5;

  xmem_cycle_gen i_xmem_cycle_gen (
    .clk(clk), .rst_n(rst_n), .stretch_sel(stretch_sel), .start(start),
    .wr_sel(wr_sel), .addr_in(addr_in), .wdata_in(wdata_in), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .addr_valid(addr_valid),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .rdata_out(rdata_out), .done(done), .busy(busy)
  );

  // reference model: each accepted access queues its per-clock pattern
  // entry bits: [4] window, [3] read strobe, [2] write strobe, [1] done, [0] capture
  logic [4:0]  plan_q[$];
  logic [4:0]  cur = '0;
  logic [15:0] m_addr = '0;
  logic [7:0]  m_wdata = '0;
  logic [7:0]  exp_rdata = '0;
  bit          m_wr = 0;
  int          m_s, m_n, m_w;

  always @(posedge clk) begin
    if (!rst_n) begin
      plan_q.delete();
      cur = '0; m_addr = '0; m_wdata = '0; exp_rdata = '0; m_wr = 0;
    end else begin
      if (start && !cur[4]) begin
        m_s = int'(stretch_sel);
        m_wr = wr_sel;
        m_n = m_wr ? m_s + 2 : m_s + 1;
        m_w = (m_s < 2) ? 1 : m_s;
        m_addr = addr_in;
        m_wdata = wdata_in;
        for (int i = 0; i < m_n; i++)
          plan_q.push_back({1'b1, !m_wr, (m_wr && i >= 1 && i <= m_w), 1'b0, 1'b0});
        plan_q.push_back({1'b0, 1'b0, 1'b0, 1'b1, !m_wr});
      end
      if (plan_q.size() > 0) cur = plan_q.pop_front();
      else cur = '0;
      if (cur[0]) exp_rdata = m_addr[7:0] ^ m_addr[15:8] ^ 8'hA5;
    end
  end

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s at %0t: actual %h expected %h", req, what, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      vectors++;
      chk(m_wr ? "R5" : "R3", "addr_valid", {15'b0, addr_valid}, {15'b0, cur[4]});
      chk("R4", "rd_stb", {15'b0, rd_stb}, {15'b0, cur[3]});
      chk("R6", "wr_stb", {15'b0, wr_stb}, {15'b0, cur[2]});
      chk("R8", "done", {15'b0, done}, {15'b0, cur[1]});
      chk("R9", "busy", {15'b0, busy}, {15'b0, cur[4]});
      chk("R3", "mem_addr", mem_addr, cur[4] ? m_addr : 16'h0);
      chk("R5", "mem_wdata", {8'b0, mem_wdata}, {8'b0, (cur[4] && m_wr) ? m_wdata : 8'h0});
      chk("R7", "rdata_out", {8'b0, rdata_out}, {8'b0, exp_rdata});
      chk("R10", "strobe overlap", {15'b0, rd_stb & wr_stb}, 16'h0);
    end
  end

  task automatic access(input logic [2:0] s, input logic wr, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    stretch_sel = s; wr_sel = wr; addr_in = a; wdata_in = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (11) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #400000;
    miscompares++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: reset state compared for several clocks
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R3 R4 R7: reads at every stretch value
    for (int s = 0; s < 8; s++) access(3'(s), 1'b0, 16'h1200 + 16'(s * 37), 8'h00);
    // R5 R6: writes at every stretch value, small values saturate
    for (int s = 0; s < 8; s++) access(3'(s), 1'b1, 16'hBE00 + 16'(s), 8'(8'h3C + s));
    // R2: stretch changed mid access has no effect
    @(negedge clk);
    stretch_sel = 3'd5; wr_sel = 1'b0; addr_in = 16'h4455; start = 1'b1;
    @(negedge clk);
    start = 1'b0; stretch_sel = 3'd0; wr_sel = 1'b1;
    repeat (10) @(negedge clk);
    // R9: start while busy with new fields is ignored
    @(negedge clk);
    stretch_sel = 3'd4; wr_sel = 1'b1; addr_in = 16'h0F0F; wdata_in = 8'h99; start = 1'b1;
    @(negedge clk);
    stretch_sel = 3'd7; wr_sel = 1'b0; addr_in = 16'hFFFF; wdata_in = 8'h11;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    start = 1'b1; stretch_sel = 3'd1;
    @(negedge clk);
    start = 1'b0;
    repeat (12) @(negedge clk);
    // R11: start held high so done and acceptance share a clock
    start = 1'b1;
    for (int k = 0; k < 12; k++) begin
      stretch_sel = 3'(k % 8); wr_sel = k[0]; addr_in = 16'h7000 + 16'(k * 291);
      wdata_in = 8'(k * 13);
      repeat (3) @(negedge clk);
    end
    start = 1'b0;
    repeat (14) @(negedge clk);
    // R1: reset in the middle of an access
    access(3'd7, 1'b1, 16'h2222, 8'h77);
    @(negedge clk);
    stretch_sel = 3'd7; wr_sel = 1'b0; addr_in = 16'h3333; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule